// File: doc/BRIEF.md
# Page-Mode Write Load Controller

This block is the device-side write path of a byte-wide nonvolatile memory that programs one page at a time. The host issues ordinary strobed byte writes through active-low chip-enable, output-enable and write-enable inputs, which arrive already synchronised to the block clock. The first accepted byte fixes the page number, taken from the address bits above the slot field. Every accepted byte goes into a page buffer and sets a bit in a loaded-slot mask. Bytes may come in any order, and a slot may be overwritten while the load is still open.

The load window stays open while bytes keep arriving. Each accepted byte restarts a byte-load timer. When that timer runs out, loading ends and a programming period starts, and `busy` is high for its whole length. At the end of the period only the slots marked as loaded are copied into the backing array, and the mask is cleared. A byte aimed at a different page during a load is dropped and sets a sticky error flag. Strobes seen while `busy` is high are ignored.

A simple registered read port gives the host access to the array contents. Both timer lengths are given in clock cycles. The address width is a parameter: a 1-Mbit part uses 17 bits, and the default is kept smaller so the modelled array stays small.

Top module: `page_write_loader`

## Requirements
- R1: After reset `busy` and `err` are 0, and every array byte reads as the erased value 8'hFF.
- R2: A single byte written to an idle block is found at its address once the programming period that follows has finished.
- R3: Several bytes of one page, loaded in any slot order, are all programmed in a single programming period. The page is address bits [ADDR_W-1:7] and the slot is bits [6:0].
- R4: A slot loaded twice in one load window is programmed with the later value.
- R5: Slots of the page that were not loaded in the current window keep their previous array contents.
- R6: `busy` rises exactly LOAD_TO clock edges after the commit edge of the last accepted byte. A byte accepted in the same cycle that the timer would expire restarts the window.
- R7: `busy` stays high for exactly PROG_CYC clock cycles.
- R8: During a load, a byte whose page differs from the latched page is not stored anywhere, and `err` goes to 1 and stays there until reset.
- R9: Write strobes that arrive while `busy` is high change no array byte and do not start a new load.
- R10: A strobe made with `oe_n` low (write inhibit) loads nothing and starts no programming period.
- R11: The address is taken when chip-enable and write-enable are first both low. The data is taken in the cycle that either of them returns high.
- R12: When a programming period ends the loaded-slot mask is empty, so the next load programs only its own slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Synchronised chip enable, active low |
| oe_n | input | 1 | Synchronised output enable, active low; low inhibits writes |
| we_n | input | 1 | Synchronised write enable, active low |
| addr | input | ADDR_W | Byte address: page above bit 7, slot in bits [6:0] |
| din | input | DATA_W | Write data |
| rd_data | output | DATA_W | Array byte, registered when ce_n=0, oe_n=0 and we_n=1 |
| busy | output | 1 | High during the programming period |
| err | output | 1 | Sticky flag for a page-mismatched byte |

## Verification
The byte-load timer's expiry and the commit of a new byte can happen on the same clock edge. In that case the byte must win: it is stored and the window restarts, rather than programming beginning without it. The bench provokes this by timing a second byte's strobe release so that its commit edge is exactly LOAD_TO edges after the first. It then checks that `busy` stays low for another full LOAD_TO edges and that both bytes appear in the array afterwards.

// File: rtl/page_write_loader.sv
module page_write_loader #(
  parameter int          ADDR_W     = 10,
  parameter int          DATA_W     = 8,
  parameter int          PAGE_BYTES = 128,
  parameter int          LOAD_TO    = 20,
  parameter int          PROG_CYC   = 40,
  parameter logic [7:0]  ERASED     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              err
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LT_W   = $clog2(LOAD_TO + 1);
  localparam int PT_W   = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} phase_t;

  phase_t                 phase;
  logic                   strobe, strobe_q, armed;
  logic [ADDR_W-1:0]      a_lat;
  logic [PAGE_W-1:0]      page_q;
  logic [PAGE_BYTES-1:0]  mask;
  logic [LT_W-1:0]        ltimer;
  logic [PT_W-1:0]        ptimer;
  logic [DATA_W-1:0]      pbuf [PAGE_BYTES];
  logic [DATA_W-1:0]      mem  [DEPTH];

  assign strobe = ~ce_n & ~we_n;
  assign busy   = (phase == S_PROG);

  wire               take    = strobe & ~strobe_q & oe_n & ~busy;
  wire               commit  = ~strobe & strobe_q & armed & oe_n & ~busy;
  wire [PAGE_W-1:0]  cpage   = a_lat[ADDR_W-1:SLOT_W];
  wire [SLOT_W-1:0]  cslot   = a_lat[SLOT_W-1:0];
  wire               page_ok = (phase == S_IDLE) || (cpage == page_q);
  wire               accept  = commit & page_ok;
  wire               ldone   = (ltimer == LT_W'(LOAD_TO - 1));
  wire               pdone   = (ptimer == PT_W'(PROG_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed    <= 1'b0;
      a_lat    <= '0;
    end else begin
      strobe_q <= strobe;
      if (take) begin
        armed <= 1'b1;
        a_lat <= addr;
      end else if (!strobe || !oe_n) begin
        armed <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase  <= S_IDLE;
      page_q <= '0;
      mask   <= '0;
      ltimer <= '0;
      ptimer <= '0;
      err    <= 1'b0;
    end else begin
      if (commit && !page_ok) err <= 1'b1;
      if (accept) begin
        mask[cslot] <= 1'b1;
        if (phase == S_IDLE) begin
          page_q <= cpage;
          mask   <= PAGE_BYTES'(1) << cslot;
        end
      end
      case (phase)
        S_IDLE: if (accept) begin
          phase  <= S_LOAD;
          ltimer <= '0;
        end
        S_LOAD: if (accept) ltimer <= '0;
          else if (ldone) begin
            phase  <= S_PROG;
            ptimer <= '0;
          end else ltimer <= ltimer + 1'b1;
        default: if (pdone) begin
            phase <= S_IDLE;
            mask  <= '0;
          end else ptimer <= ptimer + 1'b1;
      endcase
    end

  always_ff @(posedge clk)
    if (accept) pbuf[cslot] <= din;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(ERASED);
    end else if (busy && pdone) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (mask[i]) mem[{page_q, SLOT_W'(i)}] <= pbuf[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_data <= '0;
    else if (!ce_n && !oe_n && we_n) rd_data <= mem[addr];

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  p_freeze_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mask) && $stable(page_q)));
  p_mask_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mask == '0));
  p_timeout_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(phase) == S_LOAD && $past(ltimer) == LT_W'(LOAD_TO - 1)));
  p_inhibit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !busy) |=> $stable(mask) || $fell(busy));
  p_load_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == S_LOAD) |-> (mask != '0));
endmodule

// File: tb/page_write_loader_tb.sv
module page_write_loader_tb;
  localparam int AW = 10, DW = 8, LTO = 20, PC = 40;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, rd_data;
  logic busy, err;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  page_write_loader #(.ADDR_W(AW), .DATA_W(DW), .LOAD_TO(LTO), .PROG_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .rd_data(rd_data), .busy(busy), .err(err));

  function automatic logic [AW-1:0] pa(int page, int slot);
    return AW'(page * 128 + slot);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] v);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    v = rd_data;
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_done();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    rd(pa(0, 0), v); chk("R1 erased low", v, 8'hFF);
    rd(pa(7, 127), v); chk("R1 erased high", v, 8'hFF);
  endtask

  task automatic t_single();
    logic [DW-1:0] v;
    wr(pa(1, 5), 8'h3C);
    repeat (LTO - 1) @(negedge clk);
    chk("R6 busy before timeout", busy, 0);
    @(negedge clk);
    chk("R6 busy at timeout", busy, 1);
    repeat (PC - 1) @(negedge clk);
    chk("R7 busy last cycle", busy, 1);
    @(negedge clk);
    chk("R7 busy ends", busy, 0);
    rd(pa(1, 5), v); chk("R2 single byte", v, 8'h3C);
    rd(pa(1, 6), v); chk("R5 neighbour erased", v, 8'hFF);
  endtask

  task automatic t_multi();
    logic [DW-1:0] v;
    wr(pa(2, 9), 8'h91);
    wr(pa(2, 2), 8'h22);
    wr(pa(2, 127), 8'h7F);
    wr(pa(2, 0), 8'h01);
    wr(pa(2, 2), 8'hA2);
    wait_done();
    rd(pa(2, 9), v);   chk("R3 slot 9", v, 8'h91);
    rd(pa(2, 127), v); chk("R3 slot 127", v, 8'h7F);
    rd(pa(2, 0), v);   chk("R3 slot 0", v, 8'h01);
    rd(pa(2, 2), v);   chk("R4 rewritten slot", v, 8'hA2);
  endtask

  task automatic t_partial();
    logic [DW-1:0] v;
    wr(pa(2, 9), 8'h55);
    wait_done();
    rd(pa(2, 9), v);   chk("R12 new slot", v, 8'h55);
    rd(pa(2, 2), v);   chk("R12 old slot kept", v, 8'hA2);
    rd(pa(2, 127), v); chk("R5 old slot kept", v, 8'h7F);
  endtask

  task automatic t_mismatch();
    logic [DW-1:0] v;
    wr(pa(3, 1), 8'h11);
    chk("R8 err clear", err, 0);
    wr(pa(4, 1), 8'h99);
    chk("R8 err set", err, 1);
    wait_done();
    chk("R8 err sticky", err, 1);
    rd(pa(3, 1), v); chk("R8 good byte", v, 8'h11);
    rd(pa(4, 1), v); chk("R8 dropped byte", v, 8'hFF);
  endtask

  task automatic t_busy();
    logic [DW-1:0] v;
    wr(pa(5, 0), 8'hA1);
    while (!busy) @(negedge clk);
    wr(pa(5, 0), 8'hB2);
    wr(pa(6, 3), 8'hC3);
    while (busy) @(negedge clk);
    repeat (LTO + 3) @(negedge clk);
    chk("R9 no new load", busy, 0);
    rd(pa(5, 0), v); chk("R9 kept", v, 8'hA1);
    rd(pa(6, 3), v); chk("R9 ignored", v, 8'hFF);
  endtask

  task automatic t_inhibit();
    logic [DW-1:0] v;
    addr = pa(7, 20); din = 8'h5A; oe_n = 0; ce_n = 0; we_n = 0;
    repeat (2) @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
    oe_n = 1;
    repeat (LTO + 3) @(negedge clk);
    chk("R10 no programming", busy, 0);
    rd(pa(7, 20), v); chk("R10 untouched", v, 8'hFF);
  endtask

  task automatic t_strobe_edges();
    logic [DW-1:0] v;
    addr = pa(7, 10); din = 8'hD1; ce_n = 0; we_n = 0;
    @(negedge clk);
    addr = pa(7, 11); din = 8'hD2;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
    wait_done();
    rd(pa(7, 10), v); chk("R11 late data at early address", v, 8'hD2);
    rd(pa(7, 11), v); chk("R11 late address unused", v, 8'hFF);
  endtask

  task automatic t_collision();
    logic [DW-1:0] v;
    wr(pa(6, 40), 8'hE0);
    repeat (LTO - 2) @(negedge clk);
    wr(pa(6, 41), 8'hE1);
    repeat (LTO - 1) @(negedge clk);
    chk("R6 window restarted", busy, 0);
    @(negedge clk);
    chk("R6 busy after restart", busy, 1);
    wait_done();
    rd(pa(6, 40), v); chk("R6 first byte", v, 8'hE0);
    rd(pa(6, 41), v); chk("R6 colliding byte", v, 8'hE1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_partial();
    t_busy();
    t_inhibit();
    t_strobe_edges();
    t_collision();
    t_mismatch();
    summary();
  end
endmodule